// File: doc/BRIEF.md
# Main Link Bring-Up Sequencer

This block sequences the start-up of a serial display main link. Software reaches it through a byte-wide register port. It first picks a data-rate index and a lane count, then switches the link PLL on. The PLL lock input is asynchronous, so a synchronizer brings it into the clock domain before any logic uses it. A watchdog raises a sticky flag when lock does not arrive within a set number of cycles.

Once the PLL is locked, software writes the training command code to the mode register. The sequencer then gives a one-cycle start pulse to an external training engine and waits for that engine's done and pass/fail result. The mode register reports the outcome: `0x0A` while training, `0x00` for link off and `0x01` for normal mode. Software may enable the video stream only while the link is in normal mode.

The controller has three states. LS_OFF moves to LS_TRAIN when an accepted start is written. LS_TRAIN moves to LS_NORMAL when the engine reports a pass. LS_TRAIN moves to LS_OFF on a fail, an off command or loss of link. LS_NORMAL moves to LS_TRAIN on an accepted retrain. LS_NORMAL moves to LS_OFF on an off command, loss of link or a retrain request that is refused.

Top module: `link_bringup_seq`

Register map (all reset to zero):

| Address | Name | Contents |
|---|---|---|
| 0x10 | status | bit7 = synchronized lock, bit0 = lock timeout, read-only |
| 0x11 | pll control | bit0 = PLL enable |
| 0x12 | rate select | bits [7:5] = rate index |
| 0x13 | lane select | bits [5:4] = lane count |
| 0x14 | mode | training command and outcome code |
| 0x15 | stream | bit3 = video stream enable |

## Requirements
- R1: Writing address 0x11 loads bit0 into the PLL enable: 1 turns `pll_en` on and 0 turns it off. The register reads back as `{7'b0, enable}`.
- R2: The lock input passes through a two-flop synchronizer. Status bit 7 (address 0x10) and all control decisions follow the raw input two clock edges late.
- R3: Address 0x12 holds a 3-bit rate index in bits [7:5]. Index 0 is invalid, and indices 1 to 7 mean 1620, 2160, 2430, 2700, 3240, 4320 and 5400 Mbps. Other bits read as 0, the index drives `train_rate`, and it changes only when that address is written.
- R4: Address 0x13 holds a 2-bit lane count in bits [5:4], with a largest value of 3. The count drives `train_lanes`, and other bits read as 0.
- R5: Writing 0x0A to the mode register (0x14) is accepted only when the PLL is enabled, lock is synchronized and the rate index is nonzero. An accepted start makes the mode register read 0x0A and raises `train_start` for exactly one cycle after the write edge.
- R6: A refused start (PLL off, no lock, or rate index 0) leaves the mode register at 0x00 and gives no `train_start` pulse.
- R7: In training, `train_done` with `train_pass`=1 makes the mode read 0x01 (normal). With `train_pass`=0 it makes the mode read 0x00 (off).
- R8: Writing 0x00 to the mode register turns the link off from any state and clears the video stream enable.
- R9: The video stream enable is bit 3 of address 0x15 and drives `video_en`. It can be set only in normal mode; in any other state a write of 1 is ignored and the bit reads 0.
- R10: If the PLL stays enabled without synchronized lock for LOCK_WAIT consecutive cycles, status bit 0 sets. It stays set until the PLL is disabled.
- R11: If the PLL enable or the synchronized lock drops while training or in normal mode, the link goes off on the next edge and the video stream enable clears.
- R12: While training, mode writes other than 0x00 are ignored. Outside training, `train_done` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| reg_we | input | 1 | register write strobe |
| reg_addr | input | 8 | register address |
| reg_wdata | input | 8 | register write data |
| reg_rdata | output | 8 | read data for reg_addr (combinational) |
| pll_lock_raw | input | 1 | asynchronous PLL lock indication |
| pll_en | output | 1 | link PLL enable |
| train_start | output | 1 | one-cycle training start pulse |
| train_rate | output | 3 | selected rate index |
| train_lanes | output | 2 | selected lane count |
| train_done | input | 1 | training engine finished |
| train_pass | input | 1 | training result, valid with train_done |
| video_en | output | 1 | video stream enable |

## Verification
A register write shows on `reg_rdata` and on the configuration outputs one edge after the write. `train_start` rises one edge after an accepted mode write. A done/pass result changes the mode one edge after it is presented. A change on the raw lock input reaches status bit 7 two edges later, and the timeout flag sets LOCK_WAIT edges into an unlocked span. The bench drives inputs on the falling edge and samples 1 ns after it. A behavioural model stepped on each rising edge therefore always holds the value due in that cycle. Directed checks sample at exactly the cycle counts listed above.

// File: rtl/link_seq_pkg.sv
package link_seq_pkg;
    localparam int RATE_W = 3;
    localparam int LANE_W = 2;

    localparam logic [7:0] ADR_STATUS = 8'h10;
    localparam logic [7:0] ADR_PLL    = 8'h11;
    localparam logic [7:0] ADR_RATE   = 8'h12;
    localparam logic [7:0] ADR_LANE   = 8'h13;
    localparam logic [7:0] ADR_MODE   = 8'h14;
    localparam logic [7:0] ADR_STREAM = 8'h15;

    localparam logic [7:0] MODE_OFF    = 8'h00;
    localparam logic [7:0] MODE_NORMAL = 8'h01;
    localparam logic [7:0] MODE_TRAIN  = 8'h0A;

    localparam int RATE_LSB   = 5;
    localparam int LANE_LSB   = 4;
    localparam int STREAM_BIT = 3;
    localparam int LOCK_BIT   = 7;

    typedef enum logic [1:0] {
        LS_OFF    = 2'd0,
        LS_TRAIN  = 2'd1,
        LS_NORMAL = 2'd2
    } link_state_e;
endpackage

// File: rtl/link_lock_sync.sv
module link_lock_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic d_sync
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign d_sync = chain_q[STAGES-1];

    generate
        if (STAGES == 2) begin : g_chk
            AST_SYNC_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(rst_n, 2)) |-> (d_sync == $past(d_async, 2))); // R2
        end
    endgenerate
endmodule

// File: rtl/link_lock_watch.sv
module link_lock_watch #(
    parameter int LOCK_WAIT = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pll_en,
    input  logic lock_sync,
    output logic lock_timeout
);
    localparam int CNT_W = $clog2(LOCK_WAIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LOCK_WAIT - 1);

    logic [CNT_W-1:0] wait_cnt_q;
    logic             flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_cnt_q <= '0;
            flag_q     <= 1'b0;
        end else if (!pll_en) begin
            wait_cnt_q <= '0;
            flag_q     <= 1'b0;
        end else if (lock_sync) begin
            wait_cnt_q <= '0;
        end else if (!flag_q) begin
            if (wait_cnt_q == LAST) flag_q <= 1'b1;
            else                    wait_cnt_q <= wait_cnt_q + 1'b1;
        end
    end

    assign lock_timeout = flag_q;

    AST_TOUT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_en |=> !lock_timeout); // R10
    AST_TOUT_NEEDS_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_timeout) |-> $past(pll_en && !lock_sync)); // R10
endmodule

// File: rtl/link_cfg_regs.sv
module link_cfg_regs
    import link_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [7:0]        addr,
    input  logic [7:0]        wdata,
    output logic              pll_en,
    output logic [RATE_W-1:0] rate_idx,
    output logic [LANE_W-1:0] lane_cnt
);
    logic              pll_q;
    logic [RATE_W-1:0] rate_q;
    logic [LANE_W-1:0] lane_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pll_q  <= 1'b0;
            rate_q <= '0;
            lane_q <= '0;
        end else if (we) begin
            unique case (addr)
                ADR_PLL:  pll_q  <= wdata[0];
                ADR_RATE: rate_q <= wdata[RATE_LSB +: RATE_W];
                ADR_LANE: lane_q <= wdata[LANE_LSB +: LANE_W];
                default:  ;
            endcase
        end
    end

    assign pll_en   = pll_q;
    assign rate_idx = rate_q;
    assign lane_cnt = lane_q;

    AST_RATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && addr == ADR_RATE) |=> $stable(rate_idx)); // R3
    AST_PLL_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADR_PLL) |=> (pll_en == $past(wdata[0]))); // R1
endmodule

// File: rtl/link_train_fsm.sv
module link_train_fsm
    import link_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pll_en,
    input  logic              lock_sync,
    input  logic [RATE_W-1:0] rate_idx,
    input  logic              mode_we,
    input  logic [7:0]        mode_wdata,
    input  logic              stream_we,
    input  logic              stream_wbit,
    input  logic              train_done,
    input  logic              train_pass,
    output link_state_e       state,
    output logic              train_start,
    output logic              video_en
);
    link_state_e state_q, state_n;
    logic        start_q, start_n;
    logic        video_q, video_n;
    logic        link_ok;
    logic        want_off;
    logic        want_train;
    logic        rate_ok;

    assign link_ok    = pll_en && lock_sync;
    assign rate_ok    = (rate_idx != '0);
    assign want_off   = mode_we && (mode_wdata == MODE_OFF);
    assign want_train = mode_we && (mode_wdata == MODE_TRAIN);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LS_OFF;
            start_q <= 1'b0;
            video_q <= 1'b0;
        end else begin
            state_q <= state_n;
            start_q <= start_n;
            video_q <= video_n;
        end
    end

    // next state and outputs
    always_comb begin
        state_n = state_q;
        start_n = 1'b0;
        unique case (state_q)
            LS_OFF: begin
                if (want_train && link_ok && rate_ok) begin
                    state_n = LS_TRAIN;
                    start_n = 1'b1;
                end
            end
            LS_TRAIN: begin
                if (!link_ok)        state_n = LS_OFF;
                else if (want_off)   state_n = LS_OFF;
                else if (train_done) state_n = train_pass ? LS_NORMAL : LS_OFF;
            end
            LS_NORMAL: begin
                if (!link_ok)      state_n = LS_OFF;
                else if (want_off) state_n = LS_OFF;
                else if (want_train) begin
                    if (rate_ok) begin
                        state_n = LS_TRAIN;
                        start_n = 1'b1;
                    end else begin
                        state_n = LS_OFF;
                    end
                end
            end
            default: state_n = LS_OFF;
        endcase
        video_n = (state_n == LS_NORMAL) && (stream_we ? stream_wbit : video_q);
    end

    assign state       = state_q;
    assign train_start = start_q;
    assign video_en    = video_q;

    AST_VIDEO_ONLY_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        video_en |-> (state == LS_NORMAL)); // R9
    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        train_start |=> !train_start); // R5
    AST_START_NEEDS_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        train_start |-> $past(pll_en && lock_sync && rate_idx != '0)); // R6
    AST_DONE_RESOLVES: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LS_TRAIN && train_done) |=> (state != LS_TRAIN)); // R7
    AST_OFF_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_we && mode_wdata == MODE_OFF) |=> (state == LS_OFF && !video_en)); // R8
    AST_LINK_LOSS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (state != LS_OFF && !(pll_en && lock_sync)) |=> (state == LS_OFF)); // R11
    AST_DONE_IGNORED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LS_OFF && !mode_we) |=> (state == LS_OFF)); // R12
endmodule

// File: rtl/link_bringup_seq.sv
module link_bringup_seq
    import link_seq_pkg::*;
#(
    parameter int LOCK_WAIT   = 50000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic [7:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       pll_lock_raw,
    output logic       pll_en,
    output logic       train_start,
    output logic [2:0] train_rate,
    output logic [1:0] train_lanes,
    input  logic       train_done,
    input  logic       train_pass,
    output logic       video_en
);
    logic              lock_sync;
    logic              lock_timeout;
    logic [RATE_W-1:0] rate_idx;
    logic [LANE_W-1:0] lane_cnt;
    link_state_e       state;
    logic              mode_we;
    logic              stream_we;
    logic [7:0]        mode_code;

    assign mode_we   = reg_we && (reg_addr == ADR_MODE);
    assign stream_we = reg_we && (reg_addr == ADR_STREAM);

    link_lock_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pll_lock_raw),
        .d_sync  (lock_sync)
    );

    link_lock_watch #(.LOCK_WAIT(LOCK_WAIT)) u_watch (
        .clk          (clk),
        .rst_n        (rst_n),
        .pll_en       (pll_en),
        .lock_sync    (lock_sync),
        .lock_timeout (lock_timeout)
    );

    link_cfg_regs u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .pll_en   (pll_en),
        .rate_idx (rate_idx),
        .lane_cnt (lane_cnt)
    );

    link_train_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .pll_en      (pll_en),
        .lock_sync   (lock_sync),
        .rate_idx    (rate_idx),
        .mode_we     (mode_we),
        .mode_wdata  (reg_wdata),
        .stream_we   (stream_we),
        .stream_wbit (reg_wdata[STREAM_BIT]),
        .train_done  (train_done),
        .train_pass  (train_pass),
        .state       (state),
        .train_start (train_start),
        .video_en    (video_en)
    );

    always_comb begin
        unique case (state)
            LS_TRAIN:  mode_code = MODE_TRAIN;
            LS_NORMAL: mode_code = MODE_NORMAL;
            default:   mode_code = MODE_OFF;
        endcase
    end

    always_comb begin
        reg_rdata = 8'h00;
        unique case (reg_addr)
            ADR_STATUS: begin
                reg_rdata[LOCK_BIT] = lock_sync;
                reg_rdata[0]        = lock_timeout;
            end
            ADR_PLL:    reg_rdata[0] = pll_en;
            ADR_RATE:   reg_rdata[RATE_LSB +: RATE_W] = rate_idx;
            ADR_LANE:   reg_rdata[LANE_LSB +: LANE_W] = lane_cnt;
            ADR_MODE:   reg_rdata = mode_code;
            ADR_STREAM: reg_rdata[STREAM_BIT] = video_en;
            default:    reg_rdata = 8'h00;
        endcase
    end

    assign train_rate  = rate_idx;
    assign train_lanes = lane_cnt;

    AST_TRAIN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        train_start |-> (mode_code == MODE_TRAIN)); // R5
endmodule

// File: tb/sim_link_bringup_seq.sv
module sim_link_bringup_seq;
    localparam int LW = 20;
    localparam logic [7:0] A_ST = 8'h10, A_PLL = 8'h11, A_RATE = 8'h12,
                           A_LANE = 8'h13, A_MODE = 8'h14, A_STR = 8'h15;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       pll_lock_raw = 1'b0;
    logic       pll_en;
    logic       train_start;
    logic [2:0] train_rate;
    logic [1:0] train_lanes;
    logic       train_done = 1'b0;
    logic       train_pass = 1'b0;
    logic       video_en;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done_run = 1'b0;

    always #4 clk = ~clk;

    link_bringup_seq #(.LOCK_WAIT(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pll_lock_raw(pll_lock_raw),
        .pll_en(pll_en), .train_start(train_start), .train_rate(train_rate),
        .train_lanes(train_lanes), .train_done(train_done), .train_pass(train_pass),
        .video_en(video_en)
    );

    // behavioural reference: 0 off, 1 training, 2 normal
    int   m_state, m_cnt;
    logic m_pll, m_s1, m_s2, m_start, m_video, m_tout;
    logic [2:0] m_rate;
    logic [1:0] m_lane;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state = 0; m_cnt = 0; m_pll = 0; m_s1 = 0; m_s2 = 0;
            m_start = 0; m_video = 0; m_tout = 0; m_rate = 0; m_lane = 0;
        end else begin
            int   ns;
            logic ok, wm, st, nt;
            int   nc;
            ok = m_pll && m_s2;
            wm = reg_we && reg_addr == A_MODE;
            ns = m_state; st = 0;
            if (m_state == 0) begin
                if (wm && reg_wdata == 8'h0A && ok && m_rate != 0) begin ns = 1; st = 1; end
            end else if (!ok || (wm && reg_wdata == 8'h00)) begin
                ns = 0;
            end else if (m_state == 1) begin
                if (train_done) ns = train_pass ? 2 : 0;
            end else if (wm && reg_wdata == 8'h0A) begin
                if (m_rate != 0) begin ns = 1; st = 1; end else ns = 0;
            end
            if (ns != 2) m_video = 0;
            else if (reg_we && reg_addr == A_STR) m_video = reg_wdata[3];
            nc = m_cnt; nt = m_tout;
            if (!m_pll) begin nc = 0; nt = 0; end
            else if (m_s2) nc = 0;
            else if (!m_tout) begin
                if (m_cnt == LW - 1) nt = 1; else nc = m_cnt + 1;
            end
            m_cnt = nc; m_tout = nt;
            m_state = ns; m_start = st;
            if (reg_we && reg_addr == A_PLL)  m_pll  = reg_wdata[0];
            if (reg_we && reg_addr == A_RATE) m_rate = reg_wdata[7:5];
            if (reg_we && reg_addr == A_LANE) m_lane = reg_wdata[5:4];
            m_s2 = m_s1; m_s1 = pll_lock_raw;
        end
    end

    function automatic logic [7:0] exp_rd(input logic [7:0] a);
        case (a)
            A_ST:   return {m_s2, 6'b0, m_tout};
            A_PLL:  return {7'b0, m_pll};
            A_RATE: return {m_rate, 5'b0};
            A_LANE: return {2'b0, m_lane, 4'b0};
            A_MODE: return (m_state == 1) ? 8'h0A : (m_state == 2) ? 8'h01 : 8'h00;
            A_STR:  return {4'b0, m_video, 3'b0};
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (rst_n && !done_run) begin
            chk("R1 pll_en", {7'b0, pll_en}, {7'b0, m_pll});
            chk("R3 train_rate", {5'b0, train_rate}, {5'b0, m_rate});
            chk("R4 train_lanes", {6'b0, train_lanes}, {6'b0, m_lane});
            chk("R5/R6 train_start", {7'b0, train_start}, {7'b0, m_start});
            chk("R9/R11 video_en", {7'b0, video_en}, {7'b0, m_video});
            chk("R2/R7/R10 reg_rdata", reg_rdata, exp_rd(reg_addr));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done_run) begin
            done_run = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
        @(negedge clk); reg_addr = a; #1; chk(tag, reg_rdata, e);
    endtask

    task automatic finish_train(input logic p);
        @(negedge clk); train_done = 1; train_pass = p;
        @(negedge clk); train_done = 0; train_pass = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        idle(2); rst_n = 1; idle(1);
        // reset state
        rd(A_MODE, 8'h00, "R7 reset mode");
        rd(A_PLL, 8'h00, "R1 reset pll");
        rd(A_ST, 8'h00, "R2 reset status");
        // config fields
        wr(A_RATE, 8'hFF); rd(A_RATE, 8'hE0, "R3 rate field");
        wr(A_LANE, 8'hFF); rd(A_LANE, 8'h30, "R4 lane field");
        // start with PLL off refused
        wr(A_MODE, 8'h0A); #1; chk("R6 no start pll off", {7'b0, train_start}, 8'h00);
        rd(A_MODE, 8'h00, "R6 mode after refused start");
        // PLL on, no lock: timeout
        wr(A_PLL, 8'h01); rd(A_PLL, 8'h01, "R1 pll on");
        wr(A_MODE, 8'h0A); rd(A_MODE, 8'h00, "R6 no lock refused");
        idle(LW + 2); rd(A_ST, 8'h01, "R10 timeout flag");
        // lock arrives two edges late
        @(negedge clk); pll_lock_raw = 1;
        reg_addr = A_ST; #1; chk("R2 not yet synced", reg_rdata, 8'h01);
        @(negedge clk); #1; chk("R2 one edge", reg_rdata, 8'h01);
        @(negedge clk); #1; chk("R2 two edges", reg_rdata, 8'h81);
        // rate 0 refused
        wr(A_RATE, 8'h00); wr(A_MODE, 8'h0A); #1;
        chk("R6 rate zero no start", {7'b0, train_start}, 8'h00);
        rd(A_MODE, 8'h00, "R6 rate zero mode");
        // accepted start, fail
        wr(A_RATE, 8'h60); wr(A_MODE, 8'h0A); #1;
        chk("R5 start pulse", {7'b0, train_start}, 8'h01);
        rd(A_MODE, 8'h0A, "R5 training code");
        wr(A_MODE, 8'h01); rd(A_MODE, 8'h0A, "R12 write ignored in training");
        wr(A_STR, 8'h08); rd(A_STR, 8'h00, "R9 video refused in training");
        finish_train(1'b0); rd(A_MODE, 8'h00, "R7 fail gives off");
        finish_train(1'b1); rd(A_MODE, 8'h00, "R12 done ignored when off");
        // accepted start, pass
        wr(A_MODE, 8'h0A); finish_train(1'b1); rd(A_MODE, 8'h01, "R7 pass gives normal");
        wr(A_STR, 8'hFF); rd(A_STR, 8'h08, "R9 video set in normal");
        wr(A_MODE, 8'h00); rd(A_MODE, 8'h00, "R8 off command");
        rd(A_STR, 8'h00, "R8 video cleared");
        // retrain from normal, abort with off
        wr(A_MODE, 8'h0A); finish_train(1'b1); wr(A_MODE, 8'h0A); #1;
        chk("R5 retrain pulse", {7'b0, train_start}, 8'h01);
        wr(A_MODE, 8'h00); rd(A_MODE, 8'h00, "R8 abort training");
        // lock loss in normal
        wr(A_MODE, 8'h0A); finish_train(1'b1); wr(A_STR, 8'h08);
        @(negedge clk); pll_lock_raw = 0; idle(3);
        rd(A_MODE, 8'h00, "R11 lock loss off");
        rd(A_STR, 8'h00, "R11 video cleared");
        // PLL disable clears timeout and link
        idle(LW + 2); rd(A_ST, 8'h01, "R10 timeout again");
        wr(A_PLL, 8'h00); idle(1); rd(A_ST, 8'h00, "R10 cleared by pll off");
        done_run = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule